// File: doc/BRIEF.md
# Push-Button Contrast Bias PWM

This block drives a fixed-rate pulse-width modulated output whose duty cycle sets the contrast bias of a character display. An external RC or charge-pump network turns the pulse train into a voltage. The pulse train runs at 50 kHz: a counter steps once per microsecond through 20 states. The output goes high when the counter reaches a compare value and returns low when the counter wraps to zero.

Two active-low push buttons adjust the compare value. One raises it and the other lowers it. They are sampled on a slow poll tick, every 50 ms by default. While a button is held, the value moves by one step per poll. It stops at an upper limit of 19 and a lower limit of 3. Both the microsecond tick and the poll tick come from parameterised dividers of the system clock. A new compare value is applied only at the start of a pulse period, so no period is ever cut short or stretched.

Top module: `contrast_pwm`

## Requirements
- R1: While reset is high, and immediately after it, `duty_o` equals 10 and `pwm_o` is low.
- R2: With the compare value d held constant, `pwm_o` is high for exactly 20-d microseconds in each 20-microsecond period. It is high from the count that equals d until the counter wraps to 0.
- R3: A poll tick at which only `btn_up_n` is low (pressed) raises `duty_o` by 1. One step is taken per poll tick, and poll ticks come every TICK_US microseconds.
- R4: `duty_o` never rises above 19. Pressing up at 19 leaves it at 19.
- R5: A poll tick at which only `btn_dn_n` is low lowers `duty_o` by 1.
- R6: `duty_o` never falls below 3. Pressing down at 3 leaves it at 3.
- R7: A poll tick at which both buttons are low leaves `duty_o` unchanged.
- R8: With neither button pressed, or between poll ticks, `duty_o` does not change.
- R9: The compare value used by the pulse generator changes only when the period counter wraps from 19 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_n | input | 1 | Increase button, low when pressed |
| btn_dn_n | input | 1 | Decrease button, low when pressed |
| pwm_o | output | 1 | Registered bias pulse output |
| duty_o | output | 5 | Current compare value, 3 to 19 |

## Verification
The stepping logic is driven with held-up, held-down, both-held and released patterns. Each pattern lasts a whole number of poll periods and starts midway between polls, so the expected step count is exact. Together these patterns separate a correct step from a missed poll, a double step, a wrong direction and a missing both-pressed hold. Long runs of the same button push the value against each clamp, which shows whether the limit is 19 and 3 or an off-by-one. After every pattern, the high time of the output is counted over whole pulse periods and compared with 20 minus the value. Random mixes of the four patterns then cover transitions between them.

// File: rtl/cp_pkg.sv
package cp_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic step_e decode_step(input logic up, input logic dn);
    if (up && !dn) return STEP_UP;
    if (dn && !up) return STEP_DOWN;
    return STEP_NONE;
  endfunction
endpackage

// File: rtl/cp_divider.sv
module cp_divider #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic strobe
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign strobe = en && (cnt == LAST);

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R3
endmodule

// File: rtl/cp_duty_ctrl.sv
module cp_duty_ctrl
  import cp_pkg::*;
#(
  parameter int DW        = 5,
  parameter int DUTY_INIT = 10,
  parameter int DUTY_MAX  = 19,
  parameter int DUTY_MIN  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          poll,
  input  logic          btn_up_n,
  input  logic          btn_dn_n,
  output logic [DW-1:0] duty
);
  localparam logic [DW-1:0] V_INIT = DW'(DUTY_INIT);
  localparam logic [DW-1:0] V_MAX  = DW'(DUTY_MAX);
  localparam logic [DW-1:0] V_MIN  = DW'(DUTY_MIN);

  logic [1:0] up_sync, dn_sync;
  step_e      step;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_sync <= '0;
      dn_sync <= '0;
    end else begin
      up_sync <= {up_sync[0], ~btn_up_n};
      dn_sync <= {dn_sync[0], ~btn_dn_n};
    end
  end

  assign step = decode_step(up_sync[1], dn_sync[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty <= V_INIT;
    end else if (poll) begin
      case (step)
        STEP_UP:   if (duty < V_MAX) duty <= duty + 1'b1;
        STEP_DOWN: if (duty > V_MIN) duty <= duty - 1'b1;
        default:   duty <= duty;
      endcase
    end
  end

  AST_DUTY_HIGH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    duty <= V_MAX); // R4
  AST_DUTY_LOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    duty >= V_MIN); // R6
  AST_NO_POLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !poll |=> $stable(duty)); // R8
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (poll && up_sync[1] && dn_sync[1]) |=> $stable(duty)); // R7
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (poll && up_sync[1] && !dn_sync[1] && duty < V_MAX) |=> duty == $past(duty) + 1'b1); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (poll && dn_sync[1] && !up_sync[1] && duty > V_MIN) |=> duty == $past(duty) - 1'b1); // R5
endmodule

// File: rtl/cp_pwm_core.sv
module cp_pwm_core #(
  parameter int DW        = 5,
  parameter int PERIOD    = 20,
  parameter int DUTY_INIT = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic [DW-1:0] duty,
  output logic          pwm
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] cmp_act;
  logic          wrap;

  assign wrap = us_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmp_act <= DW'(DUTY_INIT);
      pwm     <= 1'b0;
    end else begin
      if (us_tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) cmp_act <= duty;
      pwm <= ({{(DW > CW ? DW - CW : 0){1'b0}}, cnt} >= cmp_act);
    end
  end

  AST_CMP_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cmp_act)); // R9
  AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == '0); // R2
  AST_LOW_AT_START: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && cmp_act != '0) |=> !pwm); // R2
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm #(
  parameter int CLK_PER_US = 100,
  parameter int TICK_US    = 50000,
  parameter int PERIOD     = 20,
  parameter int DUTY_INIT  = 10,
  parameter int DUTY_MAX   = 19,
  parameter int DUTY_MIN   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_up_n,
  input  logic       btn_dn_n,
  output logic       pwm_o,
  output logic [4:0] duty_o
);
  localparam int DW = 5;

  logic us_tick, poll_tick;

  cp_divider #(.DIV(CLK_PER_US)) u_us_div (
    .clk(clk), .rst(rst), .en(1'b1), .strobe(us_tick)
  );

  cp_divider #(.DIV(TICK_US)) u_poll_div (
    .clk(clk), .rst(rst), .en(us_tick), .strobe(poll_tick)
  );

  cp_duty_ctrl #(
    .DW(DW), .DUTY_INIT(DUTY_INIT), .DUTY_MAX(DUTY_MAX), .DUTY_MIN(DUTY_MIN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .poll(poll_tick),
    .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n), .duty(duty_o)
  );

  cp_pwm_core #(
    .DW(DW), .PERIOD(PERIOD), .DUTY_INIT(DUTY_INIT)
  ) u_pwm (
    .clk(clk), .rst(rst), .us_tick(us_tick), .duty(duty_o), .pwm(pwm_o)
  );
endmodule

// File: tb/contrast_pwm_tb.sv
module contrast_pwm_tb;
  localparam int CPU = 2;
  localparam int TUS = 60;
  localparam int PER = 20;
  localparam int P   = CPU * TUS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_up_n = 1'b1;
  logic btn_dn_n = 1'b1;
  logic pwm_o;
  logic [4:0] duty_o;

  int checks = 0;
  int errors = 0;
  int model  = 10;
  bit done   = 0;

  always #2.5 clk = ~clk;

  contrast_pwm #(.CLK_PER_US(CPU), .TICK_US(TUS)) u_dut (
    .clk(clk), .rst(rst), .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n),
    .pwm_o(pwm_o), .duty_o(duty_o)
  );

  function automatic int next_duty(int d, bit up, bit dn);
    if (up && !dn && d < 19) return d + 1;
    if (dn && !up && d > 3)  return d - 1;
    return d;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure_pwm(string req);
    int hi = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
    @(posedge clk); #1;
    check(hi == (P / (PER * CPU)) * (PER - model) * CPU, req, hi,
          (P / (PER * CPU)) * (PER - model) * CPU);
  endtask

  task automatic hold(bit up, bit dn, int n, string req);
    btn_up_n = !up;
    btn_dn_n = !dn;
    repeat (n * P) @(posedge clk);
    #1;
    for (int k = 0; k < n; k++) model = next_duty(model, up, dn);
    btn_up_n = 1'b1;
    btn_dn_n = 1'b1;
    @(negedge clk);
    check(duty_o == model, req, duty_o, model);
    @(posedge clk); #1;
    repeat (P - 1) @(posedge clk);
    #1;
    measure_pwm("R2 pulse width");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(duty_o == 10, "R1 duty in reset", duty_o, 10);
    check(pwm_o == 1'b0, "R1 pwm in reset", pwm_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(duty_o == 10, "R1 duty after reset", duty_o, 10);
    repeat (P / 2) @(posedge clk);
    #1;
    measure_pwm("R2 initial width");
    hold(0, 0, 2, "R8 released");
    hold(1, 0, 3, "R3 up steps");
    hold(1, 0, 10, "R4 top clamp");
    hold(1, 0, 2, "R4 up at limit");
    hold(1, 1, 3, "R7 both pressed");
    hold(0, 1, 20, "R6 bottom clamp");
    hold(0, 1, 1, "R6 down at limit");
    hold(1, 1, 2, "R7 both at low limit");
    hold(0, 1, 0, "R8 zero polls");
    hold(1, 0, 4, "R3 up from floor");
    hold(0, 1, 2, "R5 down steps");
    for (int i = 0; i < 25; i++) begin
      int sel = $urandom_range(0, 3);
      int n   = $urandom_range(1, 5);
      hold(sel[0], sel[1], n, "R5 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule